// File: doc/BRIEF.md
# Presettable Programmable Divide Counter

This block is a synchronous binary up-counter, eight bits wide by default, with a parallel preset. It flags the all-ones state on an active-low terminal-count output. A reload-on-terminal control picks what happens when the count reaches all ones:
- With the control low, the counter wraps to zero and runs freely.
- With the control high, the next edge copies the preset bus into the count instead of incrementing. The counter then divides the clock by 256 minus the preset value.

Stages are chained through an active-low count-enable input. That input is normally fed from the terminal-count output of the lower stage, so an upper stage advances only on the edge where the lower stage leaves all ones. A registered carry output gives a clean divider output for a counter that is used alone. It is not used in a chain. The reload control must be tied low when not in use, which gives the free-running behaviour.

Top module: `prog_div_counter`

## Requirements
- R1: With load low, count enable low and no terminal reload pending, each rising clock edge adds one to the count.
- R2: A high on the parallel-load input copies the preset bus into the count on the next edge. This takes priority over counting, holding, wrapping and terminal reload.
- R3: The terminal-count output is low exactly while the count equals all ones (8'hFF), and high otherwise.
- R4: With the reload control low, an enabled edge at all ones returns the count to 8'h00.
- R5: With the reload control high, an enabled edge at all ones loads the preset. The terminal-count output then goes low once every 256 minus preset cycles, so preset 0 gives 256, preset 1 gives 255, preset 254 gives 2 and preset 255 gives 1 (terminal count stays low).
- R6: A high reset clears the count and the carry output at once, without waiting for a clock edge.
- R7: With the count-enable input high and load low, the count holds its value, including at all ones with reload enabled.
- R8: The carry output is high in the cycle after the one in which the count was all ones, and low otherwise.
- R9: Two stages, with the upper count enable driven by the lower terminal-count output, form a 16-bit counter that steps through all 65536 values and wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| preset_i | input | 8 | Preset value for load and terminal reload |
| load_i | input | 1 | Parallel load, active high |
| cnt_en_n_i | input | 1 | Count enable, active low (tie low when unused) |
| tc_reload_i | input | 1 | Reload preset at terminal count (tie low when unused) |
| count_o | output | 8 | Current count |
| tc_n_o | output | 1 | Terminal count, low while the count is all ones |
| carry_o | output | 1 | Registered terminal flag for a stage used alone |

## Verification
The hardest condition to reach is the upper stage of a two-stage chain reaching its own all-ones state and wrapping. That takes 65536 lower-stage clocks, and in each of them the enable crosses between the stages. The bench chains two instances with the enable wired from the lower terminal-count output. It runs the full 16-bit cycle and compares the concatenated count with an independent counter on every clock. The divide-ratio checks at presets 0 and 255 reach the two extreme lengths of the reload loop. Preset 255 is the case where the terminal state reloads into itself.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_INC    = 2'd1,
        OP_RELOAD = 2'd2,
        OP_LOAD   = 2'd3
    } pdc_op_e;

    typedef struct packed {
        logic load;
        logic hold;
        logic tc_reload;
    } pdc_ctrl_t;

endpackage

// File: rtl/pdc_op_sel.sv
`timescale 1ns/1ps
module pdc_op_sel
    import pdc_pkg::*;
(
    input  pdc_ctrl_t ctrl,
    input  logic      at_term,
    output pdc_op_e   op
);
    always_comb begin
        if (ctrl.load)
            op = OP_LOAD;
        else if (ctrl.hold)
            op = OP_HOLD;
        else if (at_term && ctrl.tc_reload)
            op = OP_RELOAD;
        else
            op = OP_INC;
    end
endmodule

// File: rtl/pdc_count_reg.sv
`timescale 1ns/1ps
module pdc_count_reg
    import pdc_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  pdc_op_e          op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            count <= '0;
        else begin
            case (op)
                OP_LOAD, OP_RELOAD: count <= preset;
                OP_INC:             count <= count + ONE;
                default:            count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pdc_term.sv
`timescale 1ns/1ps
module pdc_term #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] count,
    output logic             at_term,
    output logic             tc_n,
    output logic             carry
);
    logic [WIDTH-1:0] and_chain;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_and
            if (g == 0) begin : g_first
                assign and_chain[g] = count[g];
            end else begin : g_rest
                assign and_chain[g] = and_chain[g-1] & count[g];
            end
        end
    endgenerate

    assign at_term = and_chain[WIDTH-1];
    assign tc_n    = ~at_term;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            carry <= 1'b0;
        else
            carry <= at_term;
    end
endmodule

// File: rtl/prog_div_counter.sv
`timescale 1ns/1ps
module prog_div_counter
    import pdc_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             load_i,
    input  logic             cnt_en_n_i,
    input  logic             tc_reload_i,
    output logic [WIDTH-1:0] count_o,
    output logic             tc_n_o,
    output logic             carry_o
);
    pdc_ctrl_t ctrl;
    pdc_op_e   op;
    logic      at_term;

    assign ctrl.load      = load_i;
    assign ctrl.hold      = cnt_en_n_i;
    assign ctrl.tc_reload = tc_reload_i;

    pdc_op_sel u_op_sel (
        .ctrl    (ctrl),
        .at_term (at_term),
        .op      (op)
    );

    pdc_count_reg #(.WIDTH(WIDTH)) u_count (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .preset (preset_i),
        .count  (count_o)
    );

    pdc_term #(.WIDTH(WIDTH)) u_term (
        .clk     (clk),
        .rst     (rst),
        .count   (count_o),
        .at_term (at_term),
        .tc_n    (tc_n_o),
        .carry   (carry_o)
    );
endmodule

// File: rtl/pdc_checker.sv
`timescale 1ns/1ps
module pdc_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] preset_i,
    input logic             load_i,
    input logic             cnt_en_n_i,
    input logic             tc_reload_i,
    input logic [WIDTH-1:0] count_o,
    input logic             tc_n_o,
    input logic             carry_o
);
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !cnt_en_n_i && count_o != MAXV) |=> (count_o == $past(count_o) + 1'b1));

    p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_o == $past(preset_i)));

    p_tc_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (tc_n_o == (count_o != MAXV)));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !cnt_en_n_i && !tc_reload_i && count_o == MAXV) |=> (count_o == '0));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !cnt_en_n_i && tc_reload_i && count_o == MAXV) |=> (count_o == $past(preset_i)));

    always @(posedge clk) begin
        if (rst) begin
            p_reset_r6: assert (count_o == '0 && carry_o == 1'b0);
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_en_n_i) |=> $stable(count_o));

    p_carry_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (carry_o == ($past(count_o) == MAXV)));
endmodule

bind prog_div_counter pdc_checker #(.WIDTH(WIDTH)) u_pdc_checker (
    .clk         (clk),
    .rst         (rst),
    .preset_i    (preset_i),
    .load_i      (load_i),
    .cnt_en_n_i  (cnt_en_n_i),
    .tc_reload_i (tc_reload_i),
    .count_o     (count_o),
    .tc_n_o      (tc_n_o),
    .carry_o     (carry_o)
);

// File: tb/prog_div_counter_bench.sv
`timescale 1ns/1ps
module prog_div_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] preset = 8'h00;
    logic       load = 1'b0;
    logic       en_n = 1'b0;
    logic       tcr = 1'b0;
    logic [7:0] count, count_hi;
    logic       tc_n, tc_n_hi, carry, carry_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    prog_div_counter u_prog_div_counter (
        .clk(clk), .rst(rst), .preset_i(preset), .load_i(load),
        .cnt_en_n_i(en_n), .tc_reload_i(tcr),
        .count_o(count), .tc_n_o(tc_n), .carry_o(carry)
    );

    // upper stage of the chain, enabled by the lower terminal count
    prog_div_counter u_prog_div_counter_hi (
        .clk(clk), .rst(rst), .preset_i(preset), .load_i(load),
        .cnt_en_n_i(tc_n), .tc_reload_i(1'b0),
        .count_o(count_hi), .tc_n_o(tc_n_hi), .carry_o(carry_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load = 1'b0; en_n = 1'b0; tcr = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_val(input logic [7:0] v);
        preset = v; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R6 count after reset", count, 0);
        check("R6 carry after reset", carry, 0);
        check("R3 tc_n at zero", tc_n, 1);
        load_val(8'h5A);
        #1 rst = 1'b1;
        #0.5;
        check("R6 asynchronous clear", count, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_increment();
        do_reset();
        load_val(8'h10);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            check("R1 increment", count, 16 + i);
        end
    endtask

    task automatic t_load_priority();
        do_reset();
        en_n = 1'b1;
        load_val(8'h05);
        check("R2 load while disabled", count, 5);
        en_n = 1'b0;
        load_val(8'hFF);
        check("R3 tc_n at all ones", tc_n, 0);
        load_val(8'h33);
        check("R2 load beats wrap", count, 8'h33);
    endtask

    task automatic t_wrap();
        do_reset();
        load_val(8'hFD);
        @(negedge clk);
        check("R4 reach FE", count, 8'hFE);
        @(negedge clk);
        check("R3 tc_n low at FF", tc_n, 0);
        @(negedge clk);
        check("R4 wrap to zero", count, 0);
        check("R3 tc_n high after wrap", tc_n, 1);
    endtask

    task automatic t_hold();
        do_reset();
        load_val(8'h10);
        en_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 hold mid count", count, 8'h10);
        tcr = 1'b1;
        preset = 8'hFF;
        en_n = 1'b0;
        load_val(8'hFF);
        preset = 8'h20;
        en_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 hold at all ones with reload", count, 8'hFF);
        en_n = 1'b0;
        @(negedge clk);
        check("R5 reload after release", count, 8'h20);
        tcr = 1'b0;
    endtask

    task automatic t_carry();
        do_reset();
        load_val(8'hFE);
        check("R8 carry low at FE", carry, 0);
        @(negedge clk);
        check("R8 carry low at FF", carry, 0);
        @(negedge clk);
        check("R8 carry high after FF", carry, 1);
        @(negedge clk);
        check("R8 carry back low", carry, 0);
    endtask

    task automatic t_divide(input logic [7:0] p);
        int n;
        do_reset();
        tcr = 1'b1;
        load_val(p);
        n = 0;
        while (tc_n != 1'b0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tc_n != 1'b0 && n < 300);
        check($sformatf("R5 divide ratio preset %0d", p), n, 256 - p);
        @(negedge clk);
        check($sformatf("R5 reloaded value preset %0d", p), count, p);
        tcr = 1'b0;
    endtask

    task automatic t_chain();
        int errs;
        int first_act;
        int first_exp;
        errs = 0; first_act = 0; first_exp = 0;
        do_reset();
        for (int i = 1; i <= 65536; i++) begin
            @(negedge clk);
            if ({count_hi, count} != 16'(i)) begin
                if (errs == 0) begin
                    first_act = {count_hi, count};
                    first_exp = i % 65536;
                end
                errs++;
            end
            if (i == 65535)
                check("R9 both stages at all ones", {tc_n_hi, tc_n}, 0);
        end
        check("R9 chain first mismatch", first_act, first_exp);
        check("R9 chain wrapped to zero", {count_hi, count}, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_increment();
        t_load_priority();
        t_wrap();
        t_hold();
        t_carry();
        t_divide(8'd0);
        t_divide(8'd1);
        t_divide(8'd254);
        t_divide(8'd255);
        t_chain();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule